// File: doc/BRIEF.md
# Bus-Master DMA Control Register File

This block holds the host-visible control registers for a two-channel bus-master storage DMA engine. The host reaches a 16-byte window through a single-cycle register port that takes byte, word and dword accesses. Offset bit 3 selects the channel (0 or 1). Within each 8-byte channel half:

- byte 0 is the command register;
- byte 2 is the status register;
- bytes 4 to 7 hold the 32-bit descriptor-table pointer;
- bytes 1 and 3 are plain storage.

Size codes are 0 for a byte, 1 for a word, 2 for a dword and 3 for an invalid size. Multi-byte data is little-endian: byte lane i of the data bus maps to window offset addr+i.

Command bit 0 is the run bit and command bit 3 is the transfer direction. Status bit 0 shows that a transfer is active, bit 1 is the error flag and bit 2 is the interrupt flag.

Each channel is a two-state machine, CH_IDLE and CH_RUN. It has three transitions:

- START: a command write with bit 0 set, taken in CH_IDLE. It moves the channel to CH_RUN.
- STOP: a command write with bit 0 clear, taken in CH_RUN. It moves the channel to CH_IDLE.
- DONE: the channel's completion input. It always leads to CH_IDLE.

A START raises a one-cycle start request carrying the channel's descriptor pointer. A STOP raises a one-cycle abort request naming the drive that is selected on that channel. The descriptor walk and the data movement belong to the engine that consumes these requests.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, both status registers read 0x60, every other byte of the window reads 0, and no request or error pulse is raised.
- R2: A command write with bit 0 set to a channel in CH_IDLE moves it to CH_RUN and sets status bit 0. In the cycle after the write, start_req bit c is high for exactly one cycle and start_ptr carries that channel's pointer.
- R3: A command write with bit 0 clear to a channel in CH_RUN returns it to CH_IDLE and clears status bit 0. In the cycle after the write, abort_req bit c pulses for one cycle and abort_drive is {c, dev_sel[c]}.
- R4: While the channel is in CH_RUN, command bit 3 keeps its old value on any command write. In CH_IDLE it takes the written value.
- R5: A status write leaves bit 0 unchanged and clears bit 1 or bit 2 only where the written bit is 1. Bits 7:3 take the written value. A dma_err pulse sets bit 1.
- R6: A dword write at offset 4 or 12 loads the pointer with bits 1:0 forced to 0.
- R7: The following writes are dropped, and size_err pulses in the next cycle: a command or status write whose size is not a byte, a pointer write at offset 4 or 12 whose size is not a dword, and any write with size code 3.
- R8: A dma_done pulse clears command bit 0 and status bit 0, and sets status bit 2. This wins over a same-cycle host write to that channel: a command write is dropped, and a status write cannot clear bit 2.
- R9: When bm_enable is low, writes change no register and raise no request or size_err.
- R10: Reads return little-endian byte, word or dword data from addr upward. Bytes past offset 15 read 0, and size code 3 reads 0.
- R11: A write starting at any other offset stores each covered byte. Lanes that fall on a command, status or pointer-low byte (channel offsets 0, 2, 4), or past offset 15, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bm_enable | input | 1 | Bus mastering enabled; gates all writes |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| acc_wdata | input | 32 | Write data, lane 0 at acc_addr |
| acc_rdata | output | 32 | Combinational read data |
| dev_sel | input | 2 | Selected drive per channel |
| dma_done | input | 2 | Per-channel transfer completion pulse |
| dma_err | input | 2 | Per-channel transfer error pulse |
| start_req | output | 2 | One-cycle start request per channel |
| start_ptr | output | 32 | Descriptor pointer of the starting channel |
| abort_req | output | 2 | One-cycle abort request per channel |
| abort_drive | output | 2 | {channel, drive} of the aborted transfer |
| size_err | output | 1 | One-cycle pulse for a dropped write of illegal size |

## Verification
The hardest situations to reach are those where a completion lands in the same cycle as a host write to the same channel, and those where the direction bit must be written while a transfer is running. Both states are unreachable from a plain register sweep.

The bench first starts a channel through a command write. It then raises dma_done on the same clock edge as a status write-one-to-clear of the interrupt bit, and confirms that the interrupt stays set while the run and active bits drop. The direction freeze is driven the same way: a run is started, the direction bit is written during the run, and after the stop the bit is written again in CH_IDLE.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int CH_BYTES = 8;

    // command bits
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;
    // status bits
    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_INT = 2;

    localparam logic [7:0] STS_RESET = 8'h60;

    // channel-relative offsets with their own write rules
    localparam int OFF_CMD = 0;
    localparam int OFF_STS = 2;
    localparam int OFF_PTR = 4;

    typedef enum logic {CH_IDLE, CH_RUN} ch_state_e;

    typedef enum logic [1:0] {REG_CMD, REG_STS, REG_PTR, REG_PLAIN} reg_kind_e;

    function automatic int size_bytes(logic [1:0] sz);
        case (sz)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_special(int off);
        int r;
        r = off % CH_BYTES;
        return (r == OFF_CMD) || (r == OFF_STS) || (r == OFF_PTR);
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int WIN = NCH * CH_BYTES,
    localparam int AW  = $clog2(WIN)
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              bm_enable,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [NCH-1:0]    cmd_we,
    output logic [NCH-1:0]    sts_we,
    output logic [NCH-1:0]    ptr_we,
    output logic [WIN-1:0]    plain_we,
    output logic [WIN*8-1:0]  plain_data,
    output logic              size_bad
);

    logic      wr;
    reg_kind_e kind;
    logic      size_ok;
    int        nb;
    int        ch;
    int        off;

    assign wr = acc_valid && acc_write && bm_enable;

    always_comb begin
        nb  = size_bytes(acc_size);
        ch  = int'(acc_addr) / CH_BYTES;
        off = int'(acc_addr) % CH_BYTES;
        unique case (off)
            OFF_CMD: kind = REG_CMD;
            OFF_STS: kind = REG_STS;
            OFF_PTR: kind = REG_PTR;
            default: kind = REG_PLAIN;
        endcase
        unique case (kind)
            REG_CMD, REG_STS: size_ok = (acc_size == 2'd0);
            REG_PTR:          size_ok = (acc_size == 2'd2);
            default:          size_ok = (acc_size != 2'd3);
        endcase
    end

    assign size_bad = wr && !size_ok;

    always_comb begin
        cmd_we = '0;
        sts_we = '0;
        ptr_we = '0;
        if (wr && size_ok) begin
            for (int c = 0; c < NCH; c++) begin
                if (c == ch) begin
                    cmd_we[c] = (kind == REG_CMD);
                    sts_we[c] = (kind == REG_STS);
                    ptr_we[c] = (kind == REG_PTR);
                end
            end
        end
    end

    always_comb begin
        plain_we   = '0;
        plain_data = '0;
        for (int b = 0; b < WIN; b++) begin
            for (int i = 0; i < 4; i++) begin
                if (wr && size_ok && kind == REG_PLAIN && i < nb &&
                    int'(acc_addr) + i == b && !is_special(b)) begin
                    plain_we[b]         = 1'b1;
                    plain_data[b*8 +: 8] = acc_wdata[i*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_we,
    input  logic                  sts_we,
    input  logic                  ptr_we,
    input  logic [31:0]           wdata,
    input  logic [CH_BYTES-1:0]   plain_we,
    input  logic [CH_BYTES*8-1:0] plain_data,
    input  logic                  done,
    input  logic                  err_in,
    input  logic                  dev,
    output logic [CH_BYTES*8-1:0] regs,
    output logic                  start_pulse,
    output logic                  abort_pulse,
    output logic                  abort_dev
);

    ch_state_e   state_q, state_d;
    logic [7:1]  cmd_hi_q;
    logic [7:3]  sts_hi_q;
    logic        int_q, err_q;
    logic [7:0]  spare1_q, spare3_q;
    logic [31:0] ptr_q;

    // next state: START, STOP, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (!done && cmd_we && wdata[CMD_RUN])  state_d = CH_RUN;
            CH_RUN:  if (done)                               state_d = CH_IDLE;
                     else if (cmd_we && !wdata[CMD_RUN])     state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_hi_q    <= '0;
            sts_hi_q    <= STS_RESET[7:3];
            int_q       <= 1'b0;
            err_q       <= 1'b0;
            spare1_q    <= '0;
            spare3_q    <= '0;
            ptr_q       <= '0;
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            abort_dev   <= 1'b0;
        end else begin
            start_pulse <= (state_q == CH_IDLE) && (state_d == CH_RUN);
            abort_pulse <= (state_q == CH_RUN) && !done && cmd_we && !wdata[CMD_RUN];
            abort_dev   <= dev;
            if (cmd_we && !done) begin
                cmd_hi_q <= wdata[7:1];
                if (state_q == CH_RUN) cmd_hi_q[CMD_DIR] <= cmd_hi_q[CMD_DIR];
            end
            if (sts_we) begin
                sts_hi_q <= wdata[7:3];
                int_q    <= int_q & ~wdata[STS_INT];
                err_q    <= err_q & ~wdata[STS_ERR];
            end
            if (err_in) err_q <= 1'b1;
            if (done)   int_q <= 1'b1;
            if (ptr_we) ptr_q <= {wdata[31:2], 2'b00};
            if (plain_we[1]) spare1_q <= plain_data[15:8];
            if (plain_we[3]) spare3_q <= plain_data[31:24];
            for (int b = 5; b < CH_BYTES; b++)
                if (plain_we[b]) ptr_q[(b-4)*8 +: 8] <= plain_data[b*8 +: 8];
        end
    end

    assign regs = {ptr_q, spare3_q,
                   sts_hi_q, int_q, err_q, (state_q == CH_RUN),
                   spare1_q,
                   cmd_hi_q, (state_q == CH_RUN)};

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bm_enable,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [3:0]  acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    input  logic [1:0]  dev_sel,
    input  logic [1:0]  dma_done,
    input  logic [1:0]  dma_err,
    output logic [1:0]  start_req,
    output logic [31:0] start_ptr,
    output logic [1:0]  abort_req,
    output logic [1:0]  abort_drive,
    output logic        size_err
);

    localparam int NCH = 2;
    localparam int WIN = NCH * CH_BYTES;

    logic [NCH-1:0]   cmd_we, sts_we, ptr_we;
    logic [WIN-1:0]   plain_we;
    logic [WIN*8-1:0] plain_data;
    logic [WIN*8-1:0] win;
    logic [NCH-1:0]   abort_dev;
    logic             size_bad;

    bmdma_decode #(.NCH(NCH)) u_dec (
        .acc_valid(acc_valid), .acc_write(acc_write), .bm_enable(bm_enable),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .cmd_we(cmd_we), .sts_we(sts_we), .ptr_we(ptr_we),
        .plain_we(plain_we), .plain_data(plain_data), .size_bad(size_bad)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .cmd_we(cmd_we[c]), .sts_we(sts_we[c]), .ptr_we(ptr_we[c]),
            .wdata(acc_wdata),
            .plain_we(plain_we[c*CH_BYTES +: CH_BYTES]),
            .plain_data(plain_data[c*CH_BYTES*8 +: CH_BYTES*8]),
            .done(dma_done[c]), .err_in(dma_err[c]), .dev(dev_sel[c]),
            .regs(win[c*CH_BYTES*8 +: CH_BYTES*8]),
            .start_pulse(start_req[c]), .abort_pulse(abort_req[c]),
            .abort_dev(abort_dev[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) size_err <= 1'b0;
        else        size_err <= size_bad;
    end

    always_comb begin
        start_ptr   = '0;
        abort_drive = '0;
        for (int c = 0; c < NCH; c++) begin
            if (start_req[c]) start_ptr   = win[c*CH_BYTES*8 + 32 +: 32];
            if (abort_req[c]) abort_drive = {c[0], abort_dev[c]};
        end
    end

    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < size_bytes(acc_size) && int'(acc_addr) + i < WIN)
                acc_rdata[i*8 +: 8] = win[(int'(acc_addr) + i)*8 +: 8];
        end
    end

endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bm_enable,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [3:0]  acc_addr,
    input logic [1:0]  acc_size,
    input logic [31:0] acc_wdata,
    input logic [1:0]  dma_done,
    input logic [1:0]  start_req,
    input logic [31:0] start_ptr,
    input logic [1:0]  abort_req,
    input logic        size_err
);

    // R2 / R3: at most one request per cycle
    p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, abort_req}));

    // R2: a channel-0 start follows a legal run-bit command write
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_req[0] |-> $past(acc_valid && acc_write && bm_enable &&
            acc_addr == 4'h0 && acc_size == 2'd0 && acc_wdata[0] && !dma_done[0]));

    // R2: start request lasts one cycle
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_req[1] |=> !start_req[1]);

    // R3: a channel-1 abort follows a command write clearing the run bit
    p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req[1] |-> $past(acc_valid && acc_write && bm_enable &&
            acc_addr == 4'h8 && acc_size == 2'd0 && !acc_wdata[0]));

    // R6: a start never carries an unaligned pointer
    p_ptr_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_req) |-> (start_ptr[1:0] == 2'b00));

    // R7: size_err only follows an enabled write
    p_size_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> $past(acc_valid && acc_write && bm_enable));

    // R9: nothing is raised after a cycle with bus mastering off
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bm_enable |=> (!size_err && start_req == 2'b00 && abort_req == 2'b00));

endmodule

bind bmdma_regfile bmdma_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bm_enable(bm_enable),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .dma_done(dma_done),
    .start_req(start_req), .start_ptr(start_ptr), .abort_req(abort_req),
    .size_err(size_err)
);

// File: tb/bmdma_regfile_tb.sv
module bmdma_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bm_enable = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  dev_sel = '0;
    logic [1:0]  dma_done = '0;
    logic [1:0]  dma_err = '0;
    logic [1:0]  start_req;
    logic [31:0] start_ptr;
    logic [1:0]  abort_req;
    logic [1:0]  abort_drive;
    logic        size_err;

    always #2.5 clk = ~clk;

    bmdma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bm_enable(bm_enable),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .dev_sel(dev_sel), .dma_done(dma_done), .dma_err(dma_err),
        .start_req(start_req), .start_ptr(start_ptr), .abort_req(abort_req),
        .abort_drive(abort_drive), .size_err(size_err)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [1:0]  cap_start, cap_abort, cap_drive;
    logic [31:0] cap_ptr;
    logic        cap_err;

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h2, 2'd0, 32'h0, 32'h60,       8'd1},  // R1
        '{1'b0, 4'hA, 2'd0, 32'h0, 32'h60,       8'd1},  // R1
        '{1'b0, 4'h0, 2'd2, 32'h0, 32'h00600000, 8'd1},  // R1
        '{1'b1, 4'h4, 2'd2, 32'h12345677, 32'h0, 8'd6},  // R6
        '{1'b0, 4'h4, 2'd2, 32'h0, 32'h12345674, 8'd6},  // R6
        '{1'b1, 4'h4, 2'd0, 32'hFF, 32'h0,       8'd7},  // R7
        '{1'b0, 4'h4, 2'd2, 32'h0, 32'h12345674, 8'd7},  // R7
        '{1'b1, 4'h5, 2'd1, 32'hBEEF, 32'h0,     8'd11}, // R11
        '{1'b0, 4'h4, 2'd2, 32'h0, 32'h12BEEF74, 8'd11}, // R11
        '{1'b1, 4'h3, 2'd1, 32'hAA55, 32'h0,     8'd11}, // R11
        '{1'b0, 4'h2, 2'd1, 32'h0, 32'h5560,     8'd11}, // R11
        '{1'b1, 4'hF, 2'd2, 32'h11223344, 32'h0, 8'd11}, // R11
        '{1'b0, 4'hC, 2'd2, 32'h0, 32'h44000000, 8'd10}, // R10
        '{1'b1, 4'h8, 2'd1, 32'h1, 32'h0,        8'd7},  // R7
        '{1'b0, 4'h8, 2'd0, 32'h0, 32'h0,        8'd7},  // R7
        '{1'b1, 4'hA, 2'd0, 32'hFF, 32'h0,       8'd5},  // R5
        '{1'b0, 4'hA, 2'd0, 32'h0, 32'hF8,       8'd5},  // R5
        '{1'b0, 4'hE, 2'd2, 32'h0, 32'h4400,     8'd10}, // R10
        '{1'b1, 4'h9, 2'd0, 32'h7E, 32'h0,       8'd11}, // R11
        '{1'b0, 4'h8, 2'd1, 32'h0, 32'h7E00,     8'd11}, // R11
        '{1'b0, 4'h7, 2'd1, 32'h0, 32'h0012,     8'd10}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        cap_start = start_req; cap_ptr = start_ptr; cap_abort = abort_req;
        cap_drive = abort_drive; cap_err = size_err;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] q);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #1 q = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [1:0] m);
        @(negedge clk); dma_done = m;
        @(negedge clk); dma_done = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no pulses after reset
        check("R1 start", {30'b0, start_req}, 32'h0);
        check("R1 abort", {30'b0, abort_req}, 32'h0);
        check("R1 size_err", {31'b0, size_err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].a, VEC[i].sz, VEC[i].d);
            else begin
                rd(VEC[i].a, VEC[i].sz, q);
                check($sformatf("R%0d table %0d", VEC[i].req, i), q, VEC[i].exp);
            end
        end

        // R2: start channel 0
        dev_sel = 2'b01;
        wr(4'h0, 2'd0, 32'h01);
        check("R2 start_req", {30'b0, cap_start}, 32'h1);
        check("R2 start_ptr", cap_ptr, 32'h12BEEF74);
        rd(4'h2, 2'd0, q); check("R2 active", q, 32'h61);
        rd(4'h0, 2'd0, q); check("R2 cmd", q, 32'h01);
        // R4: direction frozen while running
        wr(4'h0, 2'd0, 32'h09);
        check("R4 no pulse", {28'b0, cap_start, cap_abort}, 32'h0);
        rd(4'h0, 2'd0, q); check("R4 frozen", q, 32'h01);
        // R3: stop
        wr(4'h0, 2'd0, 32'h08);
        check("R3 abort_req", {30'b0, cap_abort}, 32'h1);
        check("R3 abort_drive", {30'b0, cap_drive}, 32'h1);
        rd(4'h0, 2'd0, q); check("R4 frozen on stop", q, 32'h00);
        rd(4'h2, 2'd0, q); check("R3 active clr", q, 32'h60);
        wr(4'h0, 2'd0, 32'h08);
        rd(4'h0, 2'd0, q); check("R4 idle dir", q, 32'h08);

        // R2 on channel 1, then R8 done with same-cycle W1C
        wr(4'h8, 2'd0, 32'h01);
        check("R2 ch1 start_req", {30'b0, cap_start}, 32'h2);
        check("R2 ch1 ptr", cap_ptr, 32'h44000000);
        rd(4'hA, 2'd0, q); check("R2 ch1 active", q, 32'hF9);
        @(negedge clk);
        dma_done = 2'b10;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'hA; acc_size = 2'd0; acc_wdata = 32'h04;
        @(negedge clk);
        dma_done = '0; acc_valid = 1'b0; acc_write = 1'b0;
        rd(4'hA, 2'd0, q); check("R8 int wins", q, 32'h04);
        rd(4'h8, 2'd0, q); check("R8 run clr", q, 32'h00);
        wr(4'hA, 2'd0, 32'h04);
        rd(4'hA, 2'd0, q); check("R5 int w1c", q, 32'h00);

        // R5: error flag
        @(negedge clk); dma_err = 2'b01;
        @(negedge clk); dma_err = '0;
        rd(4'h2, 2'd0, q); check("R5 err set", q, 32'h62);
        wr(4'h2, 2'd0, 32'h60);
        rd(4'h2, 2'd0, q); check("R5 err kept", q, 32'h62);
        wr(4'h2, 2'd0, 32'h62);
        rd(4'h2, 2'd0, q); check("R5 err w1c", q, 32'h60);
        wr(4'h2, 2'd0, 32'h61);
        rd(4'h2, 2'd0, q); check("R5 active ro", q, 32'h60);

        // R9: disabled bus mastering
        bm_enable = 1'b0;
        wr(4'h0, 2'd0, 32'h01);
        check("R9 no start", {30'b0, cap_start}, 32'h0);
        rd(4'h0, 2'd0, q); check("R9 cmd kept", q, 32'h08);
        wr(4'h4, 2'd2, 32'hCAFE0000);
        rd(4'h4, 2'd2, q); check("R9 ptr kept", q, 32'h12BEEF74);
        wr(4'h0, 2'd1, 32'h1);
        check("R9 no size_err", {31'b0, cap_err}, 32'h0);
        bm_enable = 1'b1;

        // R7: wrong size command write
        wr(4'h0, 2'd1, 32'h0001);
        check("R7 size_err", {31'b0, cap_err}, 32'h1);
        rd(4'h0, 2'd0, q); check("R7 cmd kept", q, 32'h08);
        wr(4'h1, 2'd3, 32'hFF);
        check("R7 bad code", {31'b0, cap_err}, 32'h1);
        rd(4'h0, 2'd3, q); check("R10 bad size read", q, 32'h0);

        // R8: completion while running
        wr(4'h0, 2'd0, 32'h09);
        pulse_done(2'b01);
        rd(4'h2, 2'd0, q); check("R8 status", q, 32'h64);
        rd(4'h0, 2'd0, q); check("R8 cmd", q, 32'h08);

        finish_run();
    end

endmodule